// File: doc/BRIEF.md
# Fuse-Driven Steering Target Selector

This block runs once after every reset. It takes one sample of the fuse and enable masks that describe which units of a replicated hardware fabric are present. For each of six steering classes it then computes a group/instance pair that points at a unit that exists, so that no unicast access aimed at that pair is dropped. Each class has its own rule. Most rules start from a lowest-set-bit search over one mask. Some then scale the result or split it into fields, and one replaces a known-bad bank with an alternate bank.

A small controller sequences the work through three named states:
- **ST_SAMPLE** is the state held during reset. It moves to ST_RESOLVE on the first clock edge after reset is released, and the inputs are captured on that edge.
- **ST_RESOLVE** lasts one cycle. It moves to ST_HOLD on the next edge, and the computed targets are loaded into the output registers on that edge.
- **ST_HOLD** is final. The targets and the done flag stay frozen there until the next reset.

A two-bit mode strap selects the platform rule set: 0 is legacy, 1 is intermediate, 2 is newer and 3 is wide-group.

Top module: `steer_target_sel`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, `done` is 0 and every bit of `tgt_group`, `tgt_inst` and `class_err` is 0.
- R2: The inputs are captured on the first rising edge after reset is released. `done` rises and the targets become valid after the second edge. After that, changes on any input have no effect on the targets, and `done` stays at 1 until reset.
- R3: The MSLICE class (slot 0) has group = index of the lowest set bit of `mslice_en` and instance = 0.
- R4: The LNCF class (slot 1) has group = twice the lowest set index of `mslice_en` and instance = 0.
- R5: In modes 2 and 3, the L3 class (slot 2) has group = lowest set index of `mslice_en`. Its instance is 0 when bit 0 of `l3_bank_fuse` is 1, and 2 otherwise.
- R6: In mode 1, the L3 class takes the bank number b = 8 × (lowest set index of `mslice_en`). Its group is b[4:2] and its instance is b[1:0].
- R7: In mode 0, `l3_bank_fuse` is a disable field with 1 meaning the bank is off. The L3 instance is the lowest set index of its bitwise inverse, and the group is 0.
- R8: The DSS class (slot 3) takes d = lowest set index of `dss_en` and a per-group count P (8 in mode 3, 4 otherwise). Its group is d / P and its instance is d mod P.
- R9: The SQIDI class (slot 4) takes n = lowest set index of `node_en`. Its group is n >> 1 and its instance is n[0].
- R10: The media class (slot 5) has group 0 when `media_slice0_present` is 1 and group 1 otherwise. Its instance is always 0 and its error bit is never set.
- R11: A class whose source mask has no usable bit reports group 0, instance 0 and `class_err[slot]` = 1. For the L3 class, the source mask is the inverted disable field in mode 0 and `mslice_en` in every other mode. Class slot k occupies `tgt_group[4k+3:4k]`, `tgt_inst[4k+3:4k]` and `class_err[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| steer_mode | input | 2 | Platform rule-set strap (0 legacy, 1 intermediate, 2 newer, 3 wide-group) |
| mslice_en | input | MSL_W (4) | Memory-slice / L3 enable mask |
| l3_bank_fuse | input | BANK_W (8) | L3 bank fuse field: a disable field in mode 0, a bank mask in modes 2 and 3 |
| dss_en | input | DSS_W (32) | Sub-slice enable mask |
| node_en | input | NODE_W (8) | Node enable mask |
| media_slice0_present | input | 1 | At least one engine exists in the first media slice |
| tgt_group | output | 6×GRP_W (24) | Packed group targets, slot k at [4k+3:4k] |
| tgt_inst | output | 6×INST_W (24) | Packed instance targets, slot k at [4k+3:4k] |
| class_err | output | 6 | Per-class no-usable-unit flag |
| done | output | 1 | Targets are valid and frozen |

## Verification
The hardest behaviour to reach from the ports is the single-sample window. It is where a design that samples late, or keeps tracking its inputs, would show up. The bench attacks it by releasing reset on a falling edge and letting exactly one rising edge pass. It then drives a completely different fuse pattern before the load edge and confirms that the first pattern's targets appear. It changes the inputs again during ST_HOLD. The bench also forces every empty-mask case at once, including a legacy disable field of all ones, and steers the L3 rule away from bank 0.

// File: rtl/steer_pkg.sv
package steer_pkg;

    localparam int NUM_CLS   = 6;
    localparam int CL_MSLICE = 0;
    localparam int CL_LNCF   = 1;
    localparam int CL_L3     = 2;
    localparam int CL_DSS    = 3;
    localparam int CL_SQIDI  = 4;
    localparam int CL_MEDIA  = 5;

    typedef enum logic [1:0] {
        MODE_LEGACY = 2'd0,
        MODE_MID    = 2'd1,
        MODE_NEW    = 2'd2,
        MODE_WIDE   = 2'd3
    } steer_mode_e;

    typedef enum logic [1:0] {
        ST_SAMPLE  = 2'd0,
        ST_RESOLVE = 2'd1,
        ST_HOLD    = 2'd2
    } steer_state_e;

endpackage

// File: rtl/steer_ffs.sv
module steer_ffs #(
    parameter int W  = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          found_o
);

    always_comb begin
        idx_o   = '0;
        found_o = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o   = IW'(i);
                found_o = 1'b1;
            end
        end
    end

    always_comb begin
        if (found_o) begin
            AST_FFS_HIT_SET: assert (vec_i[idx_o] == 1'b1); // R3
        end
    end

endmodule

// File: rtl/steer_ctrl.sv
module steer_ctrl
    import steer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic cap_en_o,
    output logic load_en_o,
    output logic done_o
);

    steer_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SAMPLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SAMPLE:  state_d = ST_RESOLVE;
            ST_RESOLVE: state_d = ST_HOLD;
            ST_HOLD:    state_d = ST_HOLD;
            default:    state_d = ST_SAMPLE;
        endcase
    end

    always_comb begin
        cap_en_o  = 1'b0;
        load_en_o = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            ST_SAMPLE:  cap_en_o  = 1'b1;
            ST_RESOLVE: load_en_o = 1'b1;
            ST_HOLD:    done_o    = 1'b1;
            default:    ;
        endcase
    end

    AST_SAMPLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en_o |=> !cap_en_o); // R2

    AST_LOAD_FOLLOWS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_en_o |-> $past(cap_en_o)); // R2

endmodule

// File: rtl/steer_rules.sv
module steer_rules
    import steer_pkg::*;
#(
    parameter int MSL_W  = 4,
    parameter int BANK_W = 8,
    parameter int DSS_W  = 32,
    parameter int NODE_W = 8,
    parameter int GRP_W  = 4,
    parameter int INST_W = 4,
    localparam int MIW = (MSL_W  > 1) ? $clog2(MSL_W)  : 1,
    localparam int BIW = (BANK_W > 1) ? $clog2(BANK_W) : 1,
    localparam int DIW = (DSS_W  > 1) ? $clog2(DSS_W)  : 1,
    localparam int NIW = (NODE_W > 1) ? $clog2(NODE_W) : 1
) (
    input  steer_mode_e                mode_i,
    input  logic [MSL_W-1:0]           msl_i,
    input  logic [BANK_W-1:0]          bank_i,
    input  logic [DSS_W-1:0]           dss_i,
    input  logic [NODE_W-1:0]          node_i,
    input  logic                       media_i,
    output logic [NUM_CLS*GRP_W-1:0]   grp_o,
    output logic [NUM_CLS*INST_W-1:0]  inst_o,
    output logic [NUM_CLS-1:0]         err_o
);

    logic [MIW-1:0] m_idx;
    logic           m_hit;
    logic [BIW-1:0] b_idx;
    logic           b_hit;
    logic [DIW-1:0] d_idx;
    logic           d_hit;
    logic [NIW-1:0] n_idx;
    logic           n_hit;

    steer_ffs #(.W(MSL_W)) u_ffs_msl (
        .vec_i(msl_i), .idx_o(m_idx), .found_o(m_hit));

    steer_ffs #(.W(BANK_W)) u_ffs_bank (
        .vec_i(~bank_i), .idx_o(b_idx), .found_o(b_hit));

    steer_ffs #(.W(DSS_W)) u_ffs_dss (
        .vec_i(dss_i), .idx_o(d_idx), .found_o(d_hit));

    steer_ffs #(.W(NODE_W)) u_ffs_node (
        .vec_i(node_i), .idx_o(n_idx), .found_o(n_hit));

    logic [GRP_W-1:0]  g_a [NUM_CLS];
    logic [INST_W-1:0] i_a [NUM_CLS];
    logic [NUM_CLS-1:0] e_v;
    logic [31:0] bank_num;
    logic [31:0] d_wide;
    logic [31:0] n_wide;

    always_comb begin
        bank_num = 32'(m_idx) << 3;
        d_wide   = 32'(d_idx);
        n_wide   = 32'(n_idx);
    end

    // MSLICE and LNCF: both follow the first present memory slice
    always_comb begin
        g_a[CL_MSLICE] = m_hit ? GRP_W'(m_idx) : '0;
        i_a[CL_MSLICE] = '0;
        e_v[CL_MSLICE] = !m_hit;
        g_a[CL_LNCF]   = m_hit ? GRP_W'(32'(m_idx) << 1) : '0;
        i_a[CL_LNCF]   = '0;
        e_v[CL_LNCF]   = !m_hit;
    end

    // L3 bank: rule chosen by the platform strap
    always_comb begin
        g_a[CL_L3] = '0;
        i_a[CL_L3] = '0;
        e_v[CL_L3] = 1'b0;
        unique case (mode_i)
            MODE_LEGACY: begin
                i_a[CL_L3] = b_hit ? INST_W'(b_idx) : '0;
                e_v[CL_L3] = !b_hit;
            end
            MODE_MID: begin
                if (m_hit) begin
                    g_a[CL_L3] = GRP_W'((bank_num >> 2) & 32'd7);
                    i_a[CL_L3] = INST_W'(bank_num & 32'd3);
                end
                e_v[CL_L3] = !m_hit;
            end
            MODE_NEW, MODE_WIDE: begin
                if (m_hit) begin
                    g_a[CL_L3] = GRP_W'(m_idx);
                    i_a[CL_L3] = bank_i[0] ? INST_W'(0) : INST_W'(2);
                end
                e_v[CL_L3] = !m_hit;
            end
            default: ;
        endcase
    end

    // DSS: split lowest sub-slice into group and position in group
    always_comb begin
        g_a[CL_DSS] = '0;
        i_a[CL_DSS] = '0;
        if (d_hit) begin
            if (mode_i == MODE_WIDE) begin
                g_a[CL_DSS] = GRP_W'(d_wide >> 3);
                i_a[CL_DSS] = INST_W'(d_wide & 32'd7);
            end else begin
                g_a[CL_DSS] = GRP_W'(d_wide >> 2);
                i_a[CL_DSS] = INST_W'(d_wide & 32'd3);
            end
        end
        e_v[CL_DSS] = !d_hit;
    end

    // SQIDI node pair and media slice
    always_comb begin
        g_a[CL_SQIDI] = n_hit ? GRP_W'(n_wide >> 1) : '0;
        i_a[CL_SQIDI] = n_hit ? INST_W'(n_wide & 32'd1) : '0;
        e_v[CL_SQIDI] = !n_hit;
        g_a[CL_MEDIA] = {{(GRP_W-1){1'b0}}, ~media_i};
        i_a[CL_MEDIA] = '0;
        e_v[CL_MEDIA] = 1'b0;
    end

    for (genvar k = 0; k < NUM_CLS; k++) begin : g_pack
        assign grp_o[k*GRP_W +: GRP_W]   = g_a[k];
        assign inst_o[k*INST_W +: INST_W] = i_a[k];
    end
    assign err_o = e_v;

endmodule

// File: rtl/steer_target_sel.sv
module steer_target_sel
    import steer_pkg::*;
#(
    parameter int MSL_W  = 4,
    parameter int BANK_W = 8,
    parameter int DSS_W  = 32,
    parameter int NODE_W = 8,
    parameter int GRP_W  = 4,
    parameter int INST_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 steer_mode,
    input  logic [MSL_W-1:0]           mslice_en,
    input  logic [BANK_W-1:0]          l3_bank_fuse,
    input  logic [DSS_W-1:0]           dss_en,
    input  logic [NODE_W-1:0]          node_en,
    input  logic                       media_slice0_present,
    output logic [NUM_CLS*GRP_W-1:0]   tgt_group,
    output logic [NUM_CLS*INST_W-1:0]  tgt_inst,
    output logic [NUM_CLS-1:0]         class_err,
    output logic                       done
);

    logic cap_en, load_en;

    steer_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cap_en_o(cap_en), .load_en_o(load_en), .done_o(done));

    // one-time fuse capture
    steer_mode_e       mode_q;
    logic [MSL_W-1:0]  msl_q;
    logic [BANK_W-1:0] bank_q;
    logic [DSS_W-1:0]  dss_q;
    logic [NODE_W-1:0] node_q;
    logic              media_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= MODE_LEGACY;
            msl_q   <= '0;
            bank_q  <= '0;
            dss_q   <= '0;
            node_q  <= '0;
            media_q <= 1'b0;
        end else if (cap_en) begin
            mode_q  <= steer_mode_e'(steer_mode);
            msl_q   <= mslice_en;
            bank_q  <= l3_bank_fuse;
            dss_q   <= dss_en;
            node_q  <= node_en;
            media_q <= media_slice0_present;
        end
    end

    logic [NUM_CLS*GRP_W-1:0]  rule_grp;
    logic [NUM_CLS*INST_W-1:0] rule_inst;
    logic [NUM_CLS-1:0]        rule_err;

    steer_rules #(
        .MSL_W(MSL_W), .BANK_W(BANK_W), .DSS_W(DSS_W),
        .NODE_W(NODE_W), .GRP_W(GRP_W), .INST_W(INST_W)
    ) u_rules (
        .mode_i(mode_q), .msl_i(msl_q), .bank_i(bank_q),
        .dss_i(dss_q), .node_i(node_q), .media_i(media_q),
        .grp_o(rule_grp), .inst_o(rule_inst), .err_o(rule_err));

    // per-class target registers
    logic [GRP_W-1:0]  grp_q  [NUM_CLS];
    logic [INST_W-1:0] inst_q [NUM_CLS];
    logic [NUM_CLS-1:0] err_q;

    for (genvar k = 0; k < NUM_CLS; k++) begin : g_tgt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                grp_q[k]  <= '0;
                inst_q[k] <= '0;
                err_q[k]  <= 1'b0;
            end else if (load_en) begin
                grp_q[k]  <= rule_grp[k*GRP_W +: GRP_W];
                inst_q[k] <= rule_inst[k*INST_W +: INST_W];
                err_q[k]  <= rule_err[k];
            end
        end
        assign tgt_group[k*GRP_W +: GRP_W]  = grp_q[k];
        assign tgt_inst[k*INST_W +: INST_W] = inst_q[k];

        AST_ERR_ZERO_TGT: assert property (@(posedge clk) disable iff (!rst_n)
            (done && class_err[k]) |->
            (tgt_group[k*GRP_W +: GRP_W] == '0 && tgt_inst[k*INST_W +: INST_W] == '0)); // R11
    end
    assign class_err = err_q;

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R2

    AST_TGT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(tgt_group) && $stable(tgt_inst) && $stable(class_err))); // R2

    AST_MEDIA_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tgt_inst[CL_MEDIA*INST_W +: INST_W] == '0 && !class_err[CL_MEDIA]
                  && tgt_group[CL_MEDIA*GRP_W +: GRP_W] <= GRP_W'(1))); // R10

    AST_L3_NEW_INST: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mode_q == MODE_NEW || mode_q == MODE_WIDE) && !class_err[CL_L3]) |->
        (tgt_inst[CL_L3*INST_W +: INST_W] == INST_W'(0) ||
         tgt_inst[CL_L3*INST_W +: INST_W] == INST_W'(2))); // R5

endmodule

// File: tb/sim_steer_target_sel.sv
module sim_steer_target_sel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  steer_mode = 2'd0;
    logic [3:0]  mslice_en = '0;
    logic [7:0]  l3_bank_fuse = '0;
    logic [31:0] dss_en = '0;
    logic [7:0]  node_en = '0;
    logic        media_slice0_present = 1'b0;
    logic [23:0] tgt_group, tgt_inst;
    logic [5:0]  class_err;
    logic        done;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #2 clk = ~clk;

    steer_target_sel u0 (
        .clk(clk), .rst_n(rst_n), .steer_mode(steer_mode),
        .mslice_en(mslice_en), .l3_bank_fuse(l3_bank_fuse), .dss_en(dss_en),
        .node_en(node_en), .media_slice0_present(media_slice0_present),
        .tgt_group(tgt_group), .tgt_inst(tgt_inst),
        .class_err(class_err), .done(done));

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int lowbit(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic drive(input logic [1:0] m, input logic [3:0] ms, input logic [7:0] bk,
                         input logic [31:0] ds, input logic [7:0] nd, input logic md);
        steer_mode = m; mslice_en = ms; l3_bank_fuse = bk;
        dss_en = ds; node_en = nd; media_slice0_present = md;
    endtask

    // reset with given inputs, release, stop after the sampling edge
    task automatic boot(input logic [1:0] m, input logic [3:0] ms, input logic [7:0] bk,
                        input logic [31:0] ds, input logic [7:0] nd, input logic md);
        @(negedge clk);
        rst_n = 1'b0;
        drive(m, ms, bk, ds, nd, md);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic expect_all(input logic [1:0] m, input logic [3:0] ms, input logic [7:0] bk,
                              input logic [31:0] ds, input logic [7:0] nd, input logic md);
        int eg[6]; int ei[6]; int ee[6];
        string tag[6];
        int mi = lowbit({28'd0, ms});
        int bi = lowbit({24'd0, ~bk});
        int di = lowbit(ds);
        int ni = lowbit({24'd0, nd});
        int per = (m == 2'd3) ? 8 : 4;
        tag[0] = "R3"; tag[1] = "R4"; tag[3] = "R8"; tag[4] = "R9"; tag[5] = "R10";
        tag[2] = (m == 2'd0) ? "R7" : (m == 2'd1) ? "R6" : "R5";
        for (int k = 0; k < 6; k++) begin eg[k] = 0; ei[k] = 0; ee[k] = 0; end
        if (mi >= 0) begin eg[0] = mi; eg[1] = 2 * mi; end else begin ee[0] = 1; ee[1] = 1; end
        if (m == 2'd0) begin
            if (bi >= 0) ei[2] = bi; else ee[2] = 1;
        end else if (mi < 0) begin
            ee[2] = 1;
        end else if (m == 2'd1) begin
            eg[2] = ((mi * 8) >> 2) & 7; ei[2] = (mi * 8) & 3;
        end else begin
            eg[2] = mi; ei[2] = bk[0] ? 0 : 2;
        end
        if (di >= 0) begin eg[3] = di / per; ei[3] = di % per; end else ee[3] = 1;
        if (ni >= 0) begin eg[4] = ni >> 1; ei[4] = ni & 1; end else ee[4] = 1;
        eg[5] = md ? 0 : 1;
        chk("R2", "done", int'(done), 1);
        for (int k = 0; k < 6; k++) begin
            chk(tag[k], $sformatf("group slot %0d", k), int'(tgt_group[k*4 +: 4]), eg[k]);
            chk(tag[k], $sformatf("inst slot %0d", k), int'(tgt_inst[k*4 +: 4]), ei[k]);
            chk("R11", $sformatf("err slot %0d", k), int'(class_err[k]), ee[k]);
        end
    endtask

    task automatic run_case(input logic [1:0] m, input logic [3:0] ms, input logic [7:0] bk,
                            input logic [31:0] ds, input logic [7:0] nd, input logic md);
        boot(m, ms, bk, ds, nd, md);
        chk("R2", "done after sampling edge", int'(done), 0);
        @(negedge clk);
        expect_all(m, ms, bk, ds, nd, md);
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        rst_n = 1'b0;
        drive(2'd2, 4'b0100, 8'h01, 32'h100, 8'h08, 1'b0);
        @(negedge clk);
        chk("R1", "done in reset", int'(done), 0);
        chk("R1", "group in reset", int'(tgt_group), 0);
        chk("R1", "inst in reset", int'(tgt_inst), 0);
        chk("R1", "err in reset", int'(class_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "done first cycle", int'(done), 0);
        chk("R1", "group first cycle", int'(tgt_group), 0);
        chk("R1", "err first cycle", int'(class_err), 0);
    endtask

    task automatic t_newer_mode;
        run_case(2'd2, 4'b0100, 8'b0000_0101, 32'h0000_0100, 8'b0000_1000, 1'b1);
    endtask

    task automatic t_bank0_excluded;   // R5 alternate bank
        run_case(2'd2, 4'b1000, 8'b0000_0010, 32'h0000_0001, 8'b1000_0000, 1'b1);
        chk("R5", "L3 inst alternate bank", int'(tgt_inst[8 +: 4]), 2);
    endtask

    task automatic t_intermediate;     // R6
        run_case(2'd1, 4'b0010, 8'h00, 32'h0000_0060, 8'b0000_0110, 1'b0);
        run_case(2'd1, 4'b1000, 8'h00, 32'h8000_0000, 8'b0100_0000, 1'b0);
        chk("R6", "L3 group for slice 3", int'(tgt_group[8 +: 4]), 6);
        chk("R10", "media absent group", int'(tgt_group[20 +: 4]), 1);
    endtask

    task automatic t_legacy;           // R7
        run_case(2'd0, 4'b0001, 8'b0000_0111, 32'h0000_0010, 8'b0000_0001, 1'b1);
        chk("R7", "L3 legacy inst", int'(tgt_inst[8 +: 4]), 3);
    endtask

    task automatic t_wide_dss;         // R8
        run_case(2'd3, 4'b0001, 8'h01, 32'h0000_0800, 8'h02, 1'b1);
        chk("R8", "wide dss group", int'(tgt_group[12 +: 4]), 1);
        chk("R8", "wide dss inst", int'(tgt_inst[12 +: 4]), 3);
        run_case(2'd2, 4'b0001, 8'h01, 32'h0000_0800, 8'h02, 1'b1);
        chk("R8", "narrow dss group", int'(tgt_group[12 +: 4]), 2);
    endtask

    task automatic t_zero_masks;       // R11
        run_case(2'd2, 4'b0000, 8'h00, 32'h0, 8'h00, 1'b1);
        chk("R11", "err vector newer", int'(class_err), 6'b01_1111);
        run_case(2'd0, 4'b0010, 8'hFF, 32'h4, 8'h04, 1'b0);
        chk("R11", "legacy all disabled err", int'(class_err[2]), 1);
    endtask

    task automatic t_late_change;      // R2
        boot(2'd2, 4'b0010, 8'h01, 32'h0000_0004, 8'h02, 1'b1);
        drive(2'd0, 4'b1000, 8'hF0, 32'h8000_0000, 8'h80, 1'b0);
        @(negedge clk);
        expect_all(2'd2, 4'b0010, 8'h01, 32'h0000_0004, 8'h02, 1'b1);
        drive(2'd3, 4'b0000, 8'hFF, 32'h0, 8'h00, 1'b1);
        repeat (5) @(negedge clk);
        expect_all(2'd2, 4'b0010, 8'h01, 32'h0000_0004, 8'h02, 1'b1);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1;
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset_state();
        t_newer_mode();
        t_bank0_excluded();
        t_intermediate();
        t_legacy();
        t_wide_dss();
        t_zero_masks();
        t_late_change();
        finish_run();
    end

endmodule